// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose input pads and turns configured conditions on them into interrupt requests. Every pad is first brought into the clock domain through a two-stage synchroniser. A third stage keeps the previous sample, and comparing the two stages gives the edge events. Each pin has its own configuration word and its own sticky status bit. The configuration selects level or edge sensing, the polarity, whether detected events may latch status, whether the pin takes part in the combined interrupt, and which of seven interrupt targets it reports to.

Software reaches the registers through a single-cycle write port and a registered read port. The address is split as `{pin, select}`, where the two low bits select the configuration word (0), the status bit (1) or the synchronised input level (2). A build parameter chooses the width of the detection field. The 2-bit form detects both edges natively. The 1-bit form pairs an edge/level bit with the polarity bit, and software has to flip the polarity itself to catch both edges. A second build parameter chooses whether a status bit is acknowledged by writing 1 or by writing 0.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration word and every status bit reads 0 and `irq_out` is 0.
- R2: The configuration word has this layout: bit 0 is the interrupt enable, bit 1 the status-latch enable, bit 2 the polarity, bits 4:3 the detection field and bits 7:5 the target. It reads back as written, except that with a 1-bit detection field bit 4 always reads 0.
- R3: With the 2-bit detection field, value 1 latches status on a rising pad edge, 2 on a falling edge and 3 on either edge. Status is readable as set at most three clocks after the pad change.
- R4: With detection value 0 the pin is level sensed. Status latches while the synchronised pad equals the polarity bit (1 = active high, 0 = active low).
- R5: With the 1-bit detection field, value 1 selects edge sensing, and polarity 1 picks the rising edge while polarity 0 picks the falling edge.
- R6: While the status-latch enable is 0, no event sets status. Turning that enable on or off does not by itself set status, and a status bit that is already set stays set until it is acknowledged.
- R7: The interrupt enable affects only `irq_out`. Status still latches while the pin is disabled.
- R8: With ACK_HIGH=1, writing 1 to bit 0 of a status address clears it and writing 0 does nothing. With ACK_HIGH=0 the meaning of the two values is swapped. Writes to the input-level address change nothing.
- R9: When a detection event and an acknowledge of the same pin fall in the same cycle, the status stays set.
- R10: `irq_out[t-1]` is the registered OR, over all pins whose target is t, of status AND interrupt enable. Target 0 drives no output.
- R11: Reading the input-level address of a pin returns the synchronised pad level in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | PIN_W+2 | Pin index above a 2-bit register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after the address |
| irq_out | output | 7 | Combined interrupt per target 1..7 |

## Verification
An acknowledge write and a new detection event can land on the same pin in the same cycle. The bench provokes this with a rising pad edge timed so that its event is present at the very clock edge that takes the acknowledge write. It then reads the status, which must still be set. As a control, a plain acknowledge with no event must clear the bit, and a level-sensed pin must re-set at once after it is acknowledged. Constrained-random steps mix configuration writes, acknowledges and pad changes, and compare every status bit and every interrupt output against a model in the bench.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int TGT_W = 3;
  localparam int DET_FW = 2;

  typedef struct packed {
    logic [TGT_W-1:0]  target;
    logic [DET_FW-1:0] detect;
    logic              polarity;
    logic              raw_en;
    logic              enable;
  } gid_cfg_t;

  localparam int CFG_W = $bits(gid_cfg_t);

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LVL  = 2'd2,
    SEL_RSVD = 2'd3
  } gid_sel_e;
endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pad,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      lvl  <= '0;
      prev <= '0;
    end else begin
      meta <= pad;
      lvl  <= meta;
      prev <= lvl;
    end
  end
endmodule

// File: rtl/gid_pin.sv
module gid_pin
  import gid_pkg::*;
#(
  parameter int DET_W    = 2,
  parameter bit ACK_HIGH = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_we,
  input  logic     stat_we,
  input  logic     stat_wbit,
  input  gid_cfg_t cfg_wdata,
  input  logic     lvl,
  input  logic     prev,
  output gid_cfg_t cfg,
  output logic     status,
  output logic     hit,
  output logic     clr
);
  logic     rise, fall, lvl_hit, sense;
  gid_cfg_t cfg_next;

  assign rise    = lvl & ~prev;
  assign fall    = ~lvl & prev;
  assign lvl_hit = (lvl == cfg.polarity);

  generate
    if (DET_W == 2) begin : g_det2
      always_comb begin
        unique case (cfg.detect)
          2'd0:    sense = lvl_hit;
          2'd1:    sense = rise;
          2'd2:    sense = fall;
          default: sense = rise | fall;
        endcase
      end
    end else begin : g_det1
      always_comb begin
        if (cfg.detect[0]) sense = cfg.polarity ? rise : fall;
        else               sense = lvl_hit;
      end
    end
  endgenerate

  always_comb begin
    cfg_next = cfg_wdata;
    if (DET_W == 1) cfg_next.detect[1] = 1'b0;
  end

  assign hit = cfg.raw_en & sense;
  assign clr = stat_we & (stat_wbit == ACK_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      status <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_next;
      if (hit)      status <= 1'b1;
      else if (clr) status <= 1'b0;
    end
  end
endmodule

// File: rtl/gid_route.sv
module gid_route #(
  parameter int N     = 8,
  parameter int TGT_W = 3,
  parameter int T     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     stat,
  input  logic [N-1:0]     en,
  input  logic [N*TGT_W-1:0] tgt,
  output logic [T-1:0]     irq
);
  logic [T-1:0] irq_n;

  always_comb begin
    irq_n = '0;
    for (int t = 0; t < T; t++) begin
      for (int p = 0; p < N; p++) begin
        if (tgt[p*TGT_W +: TGT_W] == TGT_W'(t + 1) && stat[p] && en[p])
          irq_n[t] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= irq_n;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DET_W    = 2,
  parameter bit ACK_HIGH = 1'b1,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W  = PIN_W + 2,
  localparam int TGT_CNT = (1 << TGT_W) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CFG_W-1:0]    bus_wdata,
  output logic [CFG_W-1:0]    bus_rdata,
  output logic [TGT_CNT-1:0]  irq_out
);
  logic [NUM_PINS-1:0]       lvl_vec, prev_vec;
  logic [NUM_PINS-1:0]       stat_vec, en_vec, raw_vec, hit_vec, clr_vec;
  logic [NUM_PINS*TGT_W-1:0] tgt_flat;
  gid_cfg_t                  cfg_a [NUM_PINS];
  logic [PIN_W-1:0]          pin_sel;
  gid_sel_e                  reg_sel;
  logic                      pin_ok;

  assign pin_sel = bus_addr[ADDR_W-1:2];
  assign reg_sel = gid_sel_e'(bus_addr[1:0]);
  assign pin_ok  = (int'(pin_sel) < NUM_PINS);

  gid_sync #(.N(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .pad (pad_in),
    .lvl (lvl_vec),
    .prev(prev_vec)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic cfg_we_i, stat_we_i;
      assign cfg_we_i  = bus_we && reg_sel == SEL_CFG  && pin_sel == PIN_W'(i);
      assign stat_we_i = bus_we && reg_sel == SEL_STAT && pin_sel == PIN_W'(i);

      gid_pin #(.DET_W(DET_W), .ACK_HIGH(ACK_HIGH)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we_i),
        .stat_we  (stat_we_i),
        .stat_wbit(bus_wdata[0]),
        .cfg_wdata(gid_cfg_t'(bus_wdata)),
        .lvl      (lvl_vec[i]),
        .prev     (prev_vec[i]),
        .cfg      (cfg_a[i]),
        .status   (stat_vec[i]),
        .hit      (hit_vec[i]),
        .clr      (clr_vec[i])
      );

      assign en_vec[i]                   = cfg_a[i].enable;
      assign raw_vec[i]                  = cfg_a[i].raw_en;
      assign tgt_flat[i*TGT_W +: TGT_W]  = cfg_a[i].target;
    end
  endgenerate

  gid_route #(.N(NUM_PINS), .TGT_W(TGT_W), .T(TGT_CNT)) u_route (
    .clk (clk),
    .rst (rst),
    .stat(stat_vec),
    .en  (en_vec),
    .tgt (tgt_flat),
    .irq (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (!pin_ok) begin
      bus_rdata <= '0;
    end else begin
      unique case (reg_sel)
        SEL_CFG:  bus_rdata <= cfg_a[pin_sel];
        SEL_STAT: bus_rdata <= {{(CFG_W-1){1'b0}}, stat_vec[pin_sel]};
        SEL_LVL:  bus_rdata <= {{(CFG_W-1){1'b0}}, lvl_vec[pin_sel]};
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gid_chk.sv
module gid_chk #(
  parameter int N = 8,
  parameter int T = 7
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] stat,
  input logic [N-1:0] en,
  input logic [N-1:0] raw,
  input logic [N-1:0] hit,
  input logic [N-1:0] clr,
  input logic [T-1:0] irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> (irq == '0 && stat == '0));

  assert_no_cause_no_irq_R10: assert property (@(posedge clk) disable iff (rst)
    ((stat & en) == '0) |=> (irq == '0));

  assert_pending_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~clr) != '0) |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr)));

  assert_event_beats_ack_R9: assert property (@(posedge clk) disable iff (rst)
    ((hit & clr) != '0) |=> ((stat & $past(hit & clr)) == $past(hit & clr)));

  assert_gate_blocks_set_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(raw)) == '0));
endmodule

bind gpio_irq_detect gid_chk #(.N(NUM_PINS), .T(TGT_CNT)) u_chk (
  .clk (clk),
  .rst (rst),
  .stat(stat_vec),
  .en  (en_vec),
  .raw (raw_vec),
  .hit (hit_vec),
  .clr (clr_vec),
  .irq (irq_out)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  localparam int NP = 8;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int TC = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we   [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd   [2];
  logic [DW-1:0] rdq  [2];
  logic [NP-1:0] pad  [2];
  logic [TC-1:0] irq  [2];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(NP), .DET_W(2), .ACK_HIGH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .pad_in(pad[0]), .bus_we(we[0]), .bus_addr(addr[0]),
    .bus_wdata(wd[0]), .bus_rdata(rdq[0]), .irq_out(irq[0]));

  gpio_irq_detect #(.NUM_PINS(NP), .DET_W(1), .ACK_HIGH(1'b0)) u_dut1 (
    .clk(clk), .rst(rst), .pad_in(pad[1]), .bus_we(we[1]), .bus_addr(addr[1]),
    .bus_wdata(wd[1]), .bus_rdata(rdq[1]), .irq_out(irq[1]));

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [7:0] mkcfg(int tgt, int det, int pol, int raw, int en);
    return {tgt[2:0], det[1:0], pol[0], raw[0], en[0]};
  endfunction

  function automatic logic [AW-1:0] mka(int pin, int sel);
    return {pin[2:0], sel[1:0]};
  endfunction

  function automatic bit lvl_act(logic [7:0] c, logic v);
    return (c[4:3] == 2'd0) && (v == c[2]);
  endfunction

  function automatic bit edge_ev(logic [7:0] c, logic o, logic n);
    case (c[4:3])
      2'd1:    return !o && n;
      2'd2:    return o && !n;
      2'd3:    return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [TC-1:0] exp_irq(logic [NP-1:0] st, logic [7:0] c [NP]);
    logic [TC-1:0] r = '0;
    for (int p = 0; p < NP; p++)
      if (c[p][7:5] != 3'd0 && st[p] && c[p][0]) r[c[p][7:5]-1] = 1'b1;
    return r;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int d, int pin, int sel, logic [7:0] v);
    we[d] = 1'b1; addr[d] = mka(pin, sel); wd[d] = v;
    @(negedge clk);
    we[d] = 1'b0;
  endtask

  task automatic rdreg(int d, int pin, int sel, output logic [7:0] v);
    addr[d] = mka(pin, sel);
    @(negedge clk);
    v = rdq[d];
  endtask

  task automatic setpad(int d, int pin, logic v);
    pad[d][pin] = v;
  endtask

  task automatic stat_is(string r, int d, int pin, logic e);
    logic [7:0] v;
    rdreg(d, pin, 1, v);
    chk(r, v, {7'd0, e});
  endtask

  logic [7:0] v;
  logic [7:0] mcfg [NP];
  logic [NP-1:0] mstat, opad, npad;

  initial begin
    void'($urandom(32'h1A2B3C));
    for (int d = 0; d < 2; d++) begin
      we[d] = 0; addr[d] = '0; wd[d] = '0; pad[d] = '0;
    end
    tick(4);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    rdreg(0, 3, 0, v); chk("R1 cfg", v, 0);
    rdreg(0, 3, 1, v); chk("R1 status", v, 0);
    chk("R1 irq0", irq[0], 0);
    chk("R1 irq1", irq[1], 0);

    // R2 field layout and readback
    wr(0, 2, 0, 8'h9E); rdreg(0, 2, 0, v); chk("R2 readback", v, 8'h9E);
    wr(1, 2, 0, 8'h9E); rdreg(1, 2, 0, v); chk("R2 det1 mask", v, 8'h8E);
    wr(0, 2, 0, 8'h00); wr(1, 2, 0, 8'h00);

    // R3 two-bit edge modes with latency bound
    wr(0, 0, 0, mkcfg(0, 1, 1, 1, 0));
    setpad(0, 0, 1); tick(3); stat_is("R3 rise latency", 0, 0, 1);
    wr(0, 0, 1, 8'h01); setpad(0, 0, 0); tick(4); stat_is("R3 rise ignores fall", 0, 0, 0);
    wr(0, 0, 0, mkcfg(0, 2, 1, 1, 0));
    setpad(0, 0, 1); tick(4); stat_is("R3 fall ignores rise", 0, 0, 0);
    setpad(0, 0, 0); tick(3); stat_is("R3 fall", 0, 0, 1);
    wr(0, 0, 1, 8'h01); wr(0, 0, 0, mkcfg(0, 3, 1, 1, 0));
    setpad(0, 0, 1); tick(3); stat_is("R3 both rise", 0, 0, 1);
    wr(0, 0, 1, 8'h01); setpad(0, 0, 0); tick(3); stat_is("R3 both fall", 0, 0, 1);
    wr(0, 0, 1, 8'h01); wr(0, 0, 0, 8'h00); tick(1);
    stat_is("R3 cleared", 0, 0, 0);

    // R4 level sensing both polarities
    wr(0, 1, 0, mkcfg(0, 0, 1, 1, 0)); tick(3);
    stat_is("R4 high idle", 0, 1, 0);
    setpad(0, 1, 1); tick(4); stat_is("R4 active high", 0, 1, 1);
    // R11 level readback
    rdreg(0, 1, 2, v); chk("R11 level high", v, 1);
    setpad(0, 1, 0); tick(4); wr(0, 1, 1, 8'h01); tick(1);
    stat_is("R4 clear after inactive", 0, 1, 0);
    rdreg(0, 1, 2, v); chk("R11 level low", v, 0);
    wr(0, 1, 0, mkcfg(0, 0, 0, 1, 0)); tick(3);
    stat_is("R4 active low", 0, 1, 1);
    setpad(0, 1, 1); tick(4); wr(0, 1, 1, 8'h01); wr(0, 1, 0, 8'h00);

    // R6 latch gate
    wr(0, 5, 0, mkcfg(0, 1, 1, 0, 0));
    setpad(0, 5, 1); tick(4); stat_is("R6 gated edge", 0, 5, 0);
    wr(0, 5, 0, mkcfg(0, 1, 1, 1, 0)); wr(0, 5, 0, mkcfg(0, 1, 1, 0, 0)); tick(3);
    stat_is("R6 toggle no spurious", 0, 5, 0);
    setpad(0, 5, 0); tick(4); wr(0, 5, 0, mkcfg(0, 1, 1, 1, 0));
    setpad(0, 5, 1); tick(4); stat_is("R6 ungated edge", 0, 5, 1);
    wr(0, 5, 0, mkcfg(0, 1, 1, 0, 0)); tick(3);
    stat_is("R6 pending kept", 0, 5, 1);
    wr(0, 5, 1, 8'h01); setpad(0, 5, 0); wr(0, 5, 0, 8'h00);

    // R7 and R10 enable gating and routing
    wr(0, 6, 0, mkcfg(4, 1, 1, 1, 0));
    setpad(0, 6, 1); tick(4); stat_is("R7 masked latch", 0, 6, 1);
    chk("R7 masked no irq", irq[0], 0);
    wr(0, 6, 0, mkcfg(4, 1, 1, 1, 1)); tick(2);
    chk("R10 target4", irq[0], 7'b0001000);
    wr(0, 7, 0, mkcfg(4, 1, 1, 1, 1));
    setpad(0, 7, 1); tick(4); wr(0, 6, 1, 8'h01); tick(2);
    chk("R10 shared target", irq[0], 7'b0001000);
    wr(0, 7, 1, 8'h01); tick(2);
    chk("R10 all cleared", irq[0], 0);
    wr(0, 6, 0, mkcfg(0, 1, 1, 1, 1));
    setpad(0, 6, 0); tick(4); setpad(0, 6, 1); tick(4);
    stat_is("R10 target0 status", 0, 6, 1);
    chk("R10 target0 silent", irq[0], 0);
    wr(0, 6, 1, 8'h01); wr(0, 6, 0, 8'h00); wr(0, 7, 0, 8'h00);

    // R8 acknowledge polarity, level address read-only
    wr(0, 4, 0, mkcfg(0, 1, 1, 1, 0));
    setpad(0, 4, 1); tick(4);
    wr(0, 4, 1, 8'h00); tick(1); stat_is("R8 write0 ignored", 0, 4, 1);
    wr(0, 4, 2, 8'hFF); tick(1); stat_is("R8 level write status", 0, 4, 1);
    rdreg(0, 4, 0, v); chk("R8 level write cfg", v, mkcfg(0, 1, 1, 1, 0));
    wr(0, 4, 1, 8'h01); tick(1); stat_is("R8 write1 clears", 0, 4, 0);
    wr(1, 4, 0, mkcfg(0, 1, 1, 1, 0));
    setpad(1, 4, 1); tick(4);
    wr(1, 4, 1, 8'h01); tick(1); stat_is("R8 ackhigh0 write1 ignored", 1, 4, 1);
    wr(1, 4, 1, 8'h00); tick(1); stat_is("R8 ackhigh0 write0 clears", 1, 4, 0);

    // R5 one-bit variant
    wr(1, 0, 0, mkcfg(0, 1, 1, 1, 0));
    setpad(1, 0, 1); tick(4); stat_is("R5 pol1 rise", 1, 0, 1);
    wr(1, 0, 1, 8'h00); setpad(1, 0, 0); tick(4); stat_is("R5 pol1 no fall", 1, 0, 0);
    wr(1, 0, 0, mkcfg(0, 1, 0, 1, 0));
    setpad(1, 0, 1); tick(4); stat_is("R5 pol0 no rise", 1, 0, 0);
    setpad(1, 0, 0); tick(4); stat_is("R5 pol0 fall", 1, 0, 1);
    wr(1, 0, 1, 8'h00); wr(1, 0, 0, mkcfg(0, 0, 1, 1, 0));
    setpad(1, 0, 1); tick(4); stat_is("R5 level high", 1, 0, 1);

    // R9 event and acknowledge in the same cycle
    wr(0, 3, 0, mkcfg(0, 1, 1, 1, 0));
    setpad(0, 3, 1); tick(4); stat_is("R9 setup", 0, 3, 1);
    setpad(0, 3, 0); tick(4);
    setpad(0, 3, 1); tick(2); wr(0, 3, 1, 8'h01); tick(1);
    stat_is("R9 event wins", 0, 3, 1);
    wr(0, 3, 1, 8'h01); tick(1); stat_is("R9 plain ack clears", 0, 3, 0);
    wr(0, 3, 0, mkcfg(0, 0, 1, 1, 0)); tick(2);
    wr(0, 3, 1, 8'h01); tick(1); stat_is("R9 level re-sets", 0, 3, 1);

    // Random phase on the 2-bit, ack-high instance
    for (int p = 0; p < NP; p++) begin wr(0, p, 0, 8'h00); mcfg[p] = 8'h00; end
    tick(4);
    for (int p = 0; p < NP; p++) wr(0, p, 1, 8'h01);
    mstat = '0;
    opad = pad[0];
    for (int s = 0; s < 80; s++) begin
      int pin;
      logic [7:0] c;
      logic [NP-1:0] clrm;
      pin = $urandom % NP;
      c = 8'($urandom);
      wr(0, pin, 0, c); mcfg[pin] = c;
      clrm = NP'($urandom & $urandom);
      for (int p = 0; p < NP; p++) if (clrm[p]) wr(0, p, 1, 8'h01);
      mstat &= ~clrm;
      npad = opad ^ NP'($urandom & $urandom);
      pad[0] = npad;
      tick(5);
      for (int p = 0; p < NP; p++)
        if (mcfg[p][1] && (lvl_act(mcfg[p], opad[p]) || edge_ev(mcfg[p], opad[p], npad[p])
            || lvl_act(mcfg[p], npad[p]))) mstat[p] = 1'b1;
      opad = npad;
      for (int p = 0; p < NP; p++) begin
        rdreg(0, p, 1, v);
        chk($sformatf("R3 R4 R6 random status pin%0d", p), v, {7'd0, mstat[p]});
      end
      chk("R10 random irq", irq[0], exp_irq(mstat, mcfg));
      rdreg(0, pin, 2, v);
      chk("R11 random level", v, {7'd0, opad[pin]});
    end

    summary();
    $finish;
  end
endmodule